// File: doc/BRIEF.md
# Rectangular Block Copy Engine

This engine copies a packed rectangle of pixels from a contiguous source buffer into a window of a wider frame buffer. Each pixel is three bytes wide, and all data moves as 16-bit words. Software supplies the two base addresses, the width and height of the rectangle in pixels, and the column and row where the rectangle lands. A one-cycle start pulse then launches the copy. The engine fetches one word at a time through a read port and stores each word through a write port. Both ports use a request/ready handshake.

The source is walked as one flat run of words. The destination is walked row by row. Inside a row, each word steps the address by two bytes. After the last word of a row, a larger jump takes the address to the first word of the next frame-buffer line. The landing column is rounded down to an even pixel, so that every row starts on a word boundary. The outputs report whether a copy is in flight, whether the last one finished, and whether a start was refused because of bad geometry. The done and error flags are cleared by pulses on their clear inputs.

Top module: `blit2d_engine`

## Requirements
- R1: A copy of width W and height H writes exactly H rows of W*3/2 words each, and then stops.
- R2: The first destination word goes to dst_base + (pos_x with bit 0 cleared)*3 + pos_y*FB_W*3, where FB_W is the frame-buffer line length in pixels (default 320).
- R3: Inside a row, each destination address is 2 greater than the one before it. The first word of each following row lies exactly FB_W*3 bytes after the first word of the row above it.
- R4: Source reads start at src_base and step by 2 for every word, with no gaps between rows.
- R5: The k-th word read is the k-th word written, unchanged. After a read is accepted, no further read is requested until that word has been written.
- R6: A start with W odd, W = 0 or H = 0 sets err on the next cycle. The engine stays idle: busy low, and no read or write request.
- R7: busy and done both change in the cycle after the final write is accepted: done rises and busy falls. busy is high from the cycle after an accepted start until then.
- R8: A pulse on clr_done clears done, and a pulse on clr_err clears err, unless the same flag is being set in that cycle.
- R9: A start pulse while busy is high is ignored. The copy in progress keeps its original geometry and addresses.
- R10: While a request is raised and its ready is low, the request stays high, and its address and (for writes) its data stay stable.
- R11: After reset, busy, done, err, rd_req and wr_req are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle launch pulse |
| src_base | input | ADDR_W | Byte address of the packed source image |
| dst_base | input | ADDR_W | Byte address of frame-buffer pixel (0,0) |
| width | input | DIM_W | Rectangle width in pixels |
| height | input | DIM_W | Rectangle height in rows |
| pos_x | input | DIM_W | Landing column (rounded down to even) |
| pos_y | input | DIM_W | Landing row |
| clr_done | input | 1 | Clear pulse for done |
| clr_err | input | 1 | Clear pulse for err |
| busy | output | 1 | Copy in flight |
| done | output | 1 | Last copy completed (sticky) |
| err | output | 1 | Last start refused (sticky) |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_ready | input | 1 | Read accepted; rd_data valid this cycle |
| rd_data | input | DATA_W | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | DATA_W | Write data |
| wr_ready | input | 1 | Write accepted this cycle |

## Verification
The row seam is the hardest case to reach. This is where the jump replaces the normal step, and it matters most when a stall lands on the last word of a row or on the last word of the whole copy. The bench drives many random even widths and heights, including one-row and two-pixel-wide rectangles, with random ready gaps on both ports. Every word of every row is compared against an address computed independently from its row and column. A second start with different geometry is injected in the middle of a copy, to show that the walkers keep their latched values.

// File: rtl/blit_pkg.sv
package blit_pkg;

  // words in one source/destination row
  function automatic int unsigned row_words(int unsigned w, int unsigned bpp,
                                            int unsigned step);
    return (w * bpp) / step;
  endfunction

  // first destination byte address, column forced even
  function automatic int unsigned dst_origin(int unsigned base, int unsigned x,
                                             int unsigned y, int unsigned fbw,
                                             int unsigned bpp);
    return base + (x & ~32'd1) * bpp + y * fbw * bpp;
  endfunction

  // address increment applied after the last word of a row
  function automatic int unsigned row_jump(int unsigned w, int unsigned fbw,
                                           int unsigned bpp, int unsigned step);
    return (fbw - w) * bpp + step;
  endfunction

  function automatic logic geometry_bad(int unsigned w, int unsigned h,
                                        int unsigned bpp);
    return (((w * bpp) & 32'd1) != 0) || (w == 0) || (h == 0);
  endfunction

endpackage

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 10,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  inner,
  input  logic [CNT_W-1:0]  outer,
  input  logic [ADDR_W-1:0] jump,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              row_end,
  output logic              last
);
  logic [CNT_W-1:0]  col_q, row_q, inner_q, outer_q;
  logic [ADDR_W-1:0] jump_q;

  assign row_end = (col_q == inner_q - CNT_W'(1));
  assign last    = row_end && (row_q == outer_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      col_q   <= '0;
      row_q   <= '0;
      inner_q <= '0;
      outer_q <= '0;
      jump_q  <= '0;
    end else if (load) begin
      addr    <= base;
      col_q   <= '0;
      row_q   <= '0;
      inner_q <= inner;
      outer_q <= outer;
      jump_q  <= jump;
    end else if (advance) begin
      if (row_end) begin
        col_q <= '0;
        row_q <= row_q + CNT_W'(1);
        addr  <= addr + jump_q;
      end else begin
        col_q <= col_q + CNT_W'(1);
        addr  <= addr + ADDR_W'(STEP);
      end
    end
  end

  // R3: ordinary step inside a row
  a_r3_inner_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && !row_end) |=> (addr == $past(addr) + ADDR_W'(STEP)));
  // R3: row seam uses the latched jump
  a_r3_row_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && row_end) |=> (addr == $past(addr) + $past(jump_q)));
endmodule

// File: rtl/blit_flags.sv
module blit_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_done,
  input  logic set_err,
  input  logic clr_done,
  input  logic clr_err,
  output logic done,
  output logic err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (set_done)      done <= 1'b1;
      else if (clr_done) done <= 1'b0;
      if (set_err)       err  <= 1'b1;
      else if (clr_err)  err  <= 1'b0;
    end
  end

  a_r8_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && !set_done) |=> !done);
  a_r8_clear_err: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !set_err) |=> !err);
endmodule

// File: rtl/blit2d_engine.sv
module blit2d_engine #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int FB_W   = 320,
  parameter int BPP    = 3,
  parameter int DIM_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  height,
  input  logic [DIM_W-1:0]  pos_x,
  input  logic [DIM_W-1:0]  pos_y,
  input  logic              clr_done,
  input  logic              clr_err,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ready
);
  import blit_pkg::*;

  localparam int STEP  = DATA_W / 8;
  localparam int CNT_W = $clog2(FB_W * BPP / STEP + 1) > DIM_W ?
                         $clog2(FB_W * BPP / STEP + 1) : DIM_W;

  logic              busy_q, fetch_done_q, buf_full_q;
  logic [DATA_W-1:0] buf_q;
  logic              start_ok, bad, launch, reject;
  logic              rd_fire, wr_fire, finish;
  logic              src_last, dst_last, src_row_end, dst_row_end;
  logic [CNT_W-1:0]  inner_cnt, outer_cnt;
  logic [ADDR_W-1:0] dst_start, dst_jump;

  assign start_ok  = start && !busy_q;
  assign bad       = geometry_bad(32'(width), 32'(height), BPP);
  assign launch    = start_ok && !bad;
  assign reject    = start_ok && bad;
  assign inner_cnt = CNT_W'(row_words(32'(width), BPP, STEP));
  assign outer_cnt = CNT_W'(height);
  assign dst_start = ADDR_W'(dst_origin(32'(dst_base), 32'(pos_x), 32'(pos_y), FB_W, BPP));
  assign dst_jump  = ADDR_W'(row_jump(32'(width), FB_W, BPP, STEP));

  assign rd_req  = busy_q && !fetch_done_q && !buf_full_q;
  assign wr_req  = buf_full_q;
  assign wr_data = buf_q;
  assign busy    = busy_q;
  assign rd_fire = rd_req && rd_ready;
  assign wr_fire = wr_req && wr_ready;
  assign finish  = wr_fire && dst_last;

  blit_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP)) u_src (
    .clk(clk), .rst_n(rst_n), .load(launch), .base(src_base),
    .inner(inner_cnt), .outer(outer_cnt), .jump(ADDR_W'(STEP)),
    .advance(rd_fire), .addr(rd_addr), .row_end(src_row_end), .last(src_last));

  blit_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(launch), .base(dst_start),
    .inner(inner_cnt), .outer(outer_cnt), .jump(dst_jump),
    .advance(wr_fire), .addr(wr_addr), .row_end(dst_row_end), .last(dst_last));

  blit_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_done(finish), .set_err(reject),
    .clr_done(clr_done), .clr_err(clr_err), .done(done), .err(err));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      fetch_done_q <= 1'b0;
      buf_full_q   <= 1'b0;
      buf_q        <= '0;
    end else if (launch) begin
      busy_q       <= 1'b1;
      fetch_done_q <= 1'b0;
      buf_full_q   <= 1'b0;
    end else if (busy_q) begin
      if (rd_fire) begin
        buf_q      <= rd_data;
        buf_full_q <= 1'b1;
        if (src_last) fetch_done_q <= 1'b1;
      end
      if (wr_fire) begin
        buf_full_q <= 1'b0;
        if (dst_last) busy_q <= 1'b0;
      end
    end
  end

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && !busy));
  a_r6_bad_geometry: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (err && !busy && !rd_req && !wr_req));
  a_r5_single_word: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (wr_req && !rd_req && wr_data == $past(rd_data)));
  a_r10_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ready) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
  a_r10_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));
  a_r9_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !finish) |=> busy);
endmodule

// File: tb/tb_blit2d_engine.sv
module tb_blit2d_engine;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20, DATA_W = 16, FB_W = 320, BPP = 3, DIM_W = 9;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, clr_done = 1'b0, clr_err = 1'b0;
  logic [ADDR_W-1:0] src_base = '0, dst_base = '0;
  logic [DIM_W-1:0]  width = '0, height = '0, pos_x = '0, pos_y = '0;
  logic busy, done, err, rd_req, wr_req, rd_ready = 1'b0, wr_ready = 1'b0;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;

  int tests = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] mem_word(logic [ADDR_W-1:0] a);
    return DATA_W'((32'(a) * 40503) ^ 32'h5A5A);
  endfunction
  assign rd_data = mem_word(rd_addr);

  blit2d_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FB_W(FB_W), .BPP(BPP),
                  .DIM_W(DIM_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base),
    .dst_base(dst_base), .width(width), .height(height), .pos_x(pos_x),
    .pos_y(pos_y), .clr_done(clr_done), .clr_err(clr_err), .busy(busy),
    .done(done), .err(err), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data(rd_data), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready));

  task automatic check(input string req, input logic ok, input longint act,
                       input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected destination address of word k, computed from row/column
  function automatic longint exp_dst(int dbase, int x, int y, int w, int k);
    int per_row = w * BPP / 2;
    int row = k / per_row;
    int col = k % per_row;
    int first = dbase + (x / 2) * 2 * BPP + y * FB_W * BPP;
    return longint'(first + row * FB_W * BPP + col * 2);
  endfunction

  task automatic clear_flags();
    @(negedge clk); clr_done = 1'b1; clr_err = 1'b1;
    @(negedge clk); clr_done = 1'b0; clr_err = 1'b0;
  endtask

  task automatic run_blit(input int sb, input int db, input int w, input int h,
                          input int x, input int y, input int stall_pct,
                          input bit intrude);
    int total = w * BPP / 2 * h;
    int nr = 0, nw = 0, guard = 0;
    bit final_pending = 0;
    bit prev_wstall = 0;
    logic [ADDR_W-1:0] prev_waddr = '0;
    logic [DATA_W-1:0] prev_wdata = '0;
    @(negedge clk);
    src_base = ADDR_W'(sb); dst_base = ADDR_W'(db);
    width = DIM_W'(w); height = DIM_W'(h); pos_x = DIM_W'(x); pos_y = DIM_W'(y);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 busy after start", busy === 1'b1, longint'(busy), 1);
    forever begin
      if (final_pending) begin
        check("R7 done set", done === 1'b1, longint'(done), 1);
        check("R7 busy cleared", busy === 1'b0, longint'(busy), 0);
        check("R1 word count", nw == total, nw, total);
        break;
      end
      if (intrude && guard == 6) begin
        start = 1'b1; width = 9'd2; height = 9'd1; src_base = '0; dst_base = '0;
      end else start = 1'b0;
      if (prev_wstall) begin
        check("R10 write held", wr_req === 1'b1 && wr_addr === prev_waddr &&
              wr_data === prev_wdata, longint'(wr_addr), longint'(prev_waddr));
      end
      if (rd_req && nr > nw)
        check("R5 read while buffered", 1'b0, nr - nw, 0);
      rd_ready = ($urandom_range(99) >= stall_pct);
      wr_ready = ($urandom_range(99) >= stall_pct);
      if (rd_req && rd_ready) begin
        check("R4 source address", rd_addr == ADDR_W'(sb + 2 * nr),
              longint'(rd_addr), longint'(sb + 2 * nr));
        nr++;
      end
      prev_wstall = wr_req && !wr_ready;
      prev_waddr  = wr_addr;
      prev_wdata  = wr_data;
      if (wr_req && wr_ready) begin
        if (nw == 0)
          check("R2 first destination", longint'(wr_addr) == exp_dst(db, x, y, w, 0),
                longint'(wr_addr), exp_dst(db, x, y, w, 0));
        else
          check("R3 destination walk", longint'(wr_addr) == exp_dst(db, x, y, w, nw),
                longint'(wr_addr), exp_dst(db, x, y, w, nw));
        check("R5 data order", wr_data == mem_word(ADDR_W'(sb + 2 * nw)),
              longint'(wr_data), longint'(mem_word(ADDR_W'(sb + 2 * nw))));
        nw++;
        if (nw == total) final_pending = 1;
      end
      guard++;
      if (guard > 20000) begin
        check("R1 transfer hung", 1'b0, nw, total);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0; rd_ready = 1'b0; wr_ready = 1'b0;
    @(negedge clk);
    check("R1 no request after finish", !rd_req && !wr_req,
          longint'({rd_req, wr_req}), 0);
  endtask

  task automatic bad_start(input int w, input int h);
    clear_flags();
    @(negedge clk);
    width = DIM_W'(w); height = DIM_W'(h); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 err set", err === 1'b1, longint'(err), 1);
    check("R6 stays idle", busy === 1'b0, longint'(busy), 0);
    for (int i = 0; i < 4; i++) begin
      check("R6 no requests", !rd_req && !wr_req, longint'({rd_req, wr_req}), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R11 busy reset", busy === 1'b0, longint'(busy), 0);
    check("R11 flags reset", done === 1'b0 && err === 1'b0, longint'({done, err}), 0);
    check("R11 requests reset", rd_req === 1'b0 && wr_req === 1'b0,
          longint'({rd_req, wr_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners: narrowest, single row, odd column, far corner
    run_blit(32'h100, 32'h10000, 2, 1, 0, 0, 0, 0);
    run_blit(32'h200, 32'h10000, 2, 5, 7, 3, 30, 0);
    run_blit(32'h300, 32'h20000, 16, 1, 301, 100, 50, 0);
    run_blit(32'h400, 32'h20000, 10, 4, 309, 235, 40, 1);  // R9 intrusion
    clear_flags();
    check("R8 done cleared", done === 1'b0, longint'(done), 0);

    bad_start(3, 2);
    bad_start(0, 2);
    bad_start(4, 0);
    clear_flags();
    check("R8 err cleared", err === 1'b0, longint'(err), 0);

    for (int n = 0; n < 25; n++) begin
      int w = 2 * (1 + $urandom_range(11));
      int h = 1 + $urandom_range(5);
      int x = $urandom_range(FB_W - w);
      int y = $urandom_range(40);
      run_blit(2 * $urandom_range(4000), 32'h30000 + 2 * $urandom_range(1000),
               w, h, x, y, $urandom_range(70), n % 5 == 0);
      clear_flags();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule